// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A 32-pin general-purpose I/O block with six 32-bit registers reached over a small request/response bus. Each pin is either an output, driven from the data register, or an input, whose synchronized level is captured into the data register. The same register therefore reads back driven values on outputs and sampled levels on inputs. Pins are numbered from the most significant end: pin n lives in bit (31 - n) of every register and of every pin vector.

Transitions on input pins set sticky event bits. Software picks, pin by pin, whether any change or only a high-to-low change counts as an event. Event bits are cleared by writing ones to them. A single interrupt line is high while any pending event is also unmasked.

The bus request channel is valid/ready. Writes complete on acceptance and produce no response. A read returns its data on the response channel one cycle after acceptance. A response that is not taken stays stable and blocks further requests, so back-pressure flows from `rsp_ready` to `req_ready`.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and `pin_oe` and `pin_out` are 0.
- R2: Register offsets are: 0x00 direction (1 = output), 0x04 open-drain select, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge control. Direction, open-drain, mask and control read back the last full write. Pin n is bit (31 - n).
- R3: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted read raises `rsp_valid` on the next cycle. While `rsp_ready` is low, `rsp_valid` and `rsp_data` hold.
- R4: A full write to the event register clears the bits written as 1 and leaves the others unchanged. If a new event on a bit coincides with the clearing write, the bit stays set.
- R5: `irq` is high exactly when (event AND mask) is nonzero.
- R6: `pin_in` passes through two synchronizer flops. A level on an input pin (direction 0) appears in the data register and can set an event two clocks after the flop that first samples it. Changes on output pins update neither data nor events.
- R7: With control bit 0, a rise or a fall on the pin sets its event bit. With control bit 1, only a fall sets it.
- R8: `pin_out` equals data AND direction. `pin_oe` equals direction. `pin_od` equals the open-drain register.
- R9: Accesses with `req_word` low do nothing on write and return 0 on read. Reads of unmapped or misaligned offsets return 0, and writes to them change nothing.
- R10: An event bit stays set until it is cleared by a write to the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = full 32-bit access |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| pin_in | input | 32 | External pin levels, pin n at bit 31-n |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output enables |
| pin_od | output | 32 | Open-drain selects |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that `rst_n` is held low long enough to clear the synchronizer. It also assumes that request fields are stable whenever `req_valid` is high and `req_ready` is evaluated, and that `rsp_ready` is a plain level. The bench drives every request field at the falling clock edge and keeps it there through the accepting rising edge. It changes `pin_in` only at falling edges, so each transition reaches the synchronizer as one clean step. The coincident set-and-clear case is staged by counting the two synchronizer cycles, so that the clearing write lands on the same edge as the event.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFS_DIR = 8'h00;
  localparam logic [7:0] OFS_ODS = 8'h04;
  localparam logic [7:0] OFS_DAT = 8'h08;
  localparam logic [7:0] OFS_EVT = 8'h0C;
  localparam logic [7:0] OFS_MSK = 8'h10;
  localparam logic [7:0] OFS_CTL = 8'h14;

  typedef enum logic [2:0] {
    SEL_DIR, SEL_ODS, SEL_DAT, SEL_EVT, SEL_MSK, SEL_CTL, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_DIR: return SEL_DIR;
      OFS_ODS: return SEL_ODS;
      OFS_DAT: return SEL_DAT;
      OFS_EVT: return SEL_EVT;
      OFS_MSK: return SEL_MSK;
      OFS_CTL: return SEL_CTL;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= '0;
    else        q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] set_v;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic fell, changed;
    assign fell     = prev[i] & ~cur[i];
    assign changed  = prev[i] ^ cur[i];
    assign set_v[i] = ~dir[i] & (fall_only[i] ? fell : changed);
  end

  // a fresh event outranks a clearing write on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= set_v | (evt_q & ~clr);
  end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  input  logic [DW-1:0] rd_value,
  output logic          wr_fire,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);
  logic rd_fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPIN-1:0]   req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NPIN-1:0]   rsp_data,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_od,
  output logic              irq
);
  localparam int unsigned PAD = (ADDR_W < 8) ? 8 - ADDR_W : 0;

  logic [NPIN-1:0] dir_q, ods_q, dat_q, msk_q, ctl_q, evt_q;
  logic [NPIN-1:0] cur, prev, clr, rd_value;
  logic            wr_fire, wr_ok, hi_zero;
  logic [7:0]      ofs8;
  reg_sel_e        sel;

  if (ADDR_W > 8) begin : g_wide
    assign ofs8    = req_addr[7:0];
    assign hi_zero = (req_addr[ADDR_W-1:8] == '0);
  end else begin : g_narrow
    assign ofs8    = {{PAD{1'b0}}, req_addr};
    assign hi_zero = 1'b1;
  end

  assign sel   = hi_zero ? decode_ofs(ofs8) : SEL_NONE;
  assign wr_ok = wr_fire && req_word;

  gpio_bus_port #(.DW(NPIN)) u_bus (
    .clk, .rst_n, .req_valid, .req_write, .req_ready,
    .rd_value, .wr_fire, .rsp_valid, .rsp_ready, .rsp_data
  );

  gpio_pin_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
    .clk, .rst_n, .d(pin_in), .q(cur), .q_prev(prev)
  );

  assign clr = (wr_ok && sel == SEL_EVT) ? req_wdata : '0;

  gpio_evt_unit #(.W(NPIN)) u_evt (
    .clk, .rst_n, .cur, .prev, .dir(dir_q), .fall_only(ctl_q),
    .clr, .evt_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ods_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_DIR: dir_q <= req_wdata;
        SEL_ODS: ods_q <= req_wdata;
        SEL_MSK: msk_q <= req_wdata;
        SEL_CTL: ctl_q <= req_wdata;
        default: ;
      endcase
    end
  end

  // outputs keep the written value, inputs follow the synchronized pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= '0;
    else        dat_q <= (dir_q & ((wr_ok && sel == SEL_DAT) ? req_wdata : dat_q))
                       | (~dir_q & cur);
  end

  always_comb begin
    rd_value = '0;
    if (req_word) begin
      case (sel)
        SEL_DIR: rd_value = dir_q;
        SEL_ODS: rd_value = ods_q;
        SEL_DAT: rd_value = dat_q;
        SEL_EVT: rd_value = evt_q;
        SEL_MSK: rd_value = msk_q;
        SEL_CTL: rd_value = ctl_q;
        default: rd_value = '0;
      endcase
    end
  end

  assign pin_out = dat_q & dir_q;
  assign pin_oe  = dir_q;
  assign pin_od  = ods_q;
  assign irq     = |(evt_q & msk_q);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_word,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [NPIN-1:0]   rsp_data,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   evt_q,
  input logic [NPIN-1:0]   msk_q,
  input logic              irq
);
  logic evt_clear_wr, rd_acc;
  assign evt_clear_wr = req_valid && req_ready && req_write && req_word
                        && (req_addr == ADDR_W'(8'h0C));
  assign rd_acc       = req_valid && req_ready && !req_write;

  // R3
  p_ready_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  p_rsp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R5
  p_irq_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_q != '0));
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);
  // R8
  p_out_only_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
  // R10
  p_evt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_clear_wr |=> (($past(evt_q) & ~evt_q) == '0));
  // R6
  p_no_evt_on_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & $past(pin_oe)) == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .pin_out(pin_out), .pin_oe(pin_oe), .evt_q(evt_q), .msk_q(msk_q), .irq(irq)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b1;
  logic        req_ready, rsp_valid, irq;
  logic        rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_data, pin_out, pin_oe, pin_od;
  logic [31:0] pin_in = '0;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_edge_ctrl dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_word, .req_addr,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_data, .pin_in, .pin_out,
    .pin_oe, .pin_od, .irq
  );

  typedef struct packed { logic [7:0] ofs; logic [31:0] wval; logic [31:0] exp; } vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 32'h8000_0001, 32'h8000_0001},
    '{8'h04, 32'h1234_5678, 32'h1234_5678},
    '{8'h10, 32'hF0F0_0F0F, 32'hF0F0_0F0F},
    '{8'h14, 32'h0000_FFFF, 32'h0000_FFFF},
    '{8'h18, 32'hDEAD_BEEF, 32'h0000_0000},
    '{8'h02, 32'hFFFF_FFFF, 32'h0000_0000},
    '{8'h00, 32'h0000_0000, 32'h0000_0000},
    '{8'h10, 32'h0000_0000, 32'h0000_0000},
    '{8'h14, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic word = 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_word = word;
    @(negedge clk);
    req_valid = 1'b0; req_word = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic word = 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_word = word;
    @(negedge clk);
    req_valid = 1'b0; req_word = 1'b1;
    d = rsp_valid ? rsp_data : 32'hXXXX_XXXX;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk({31'b0, irq}, 32'h0, "R1 irq");
    chk(pin_out, 32'h0, "R1 pin_out");
    chk(pin_oe, 32'h0, "R1 pin_oe");
    for (int a = 0; a < 6; a++) begin
      rd(8'(a * 4), d);
      chk(d, 32'h0, "R1 register");
    end
    // R2 / R9 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].ofs, VEC[i].wval);
      rd(VEC[i].ofs, d);
      chk(d, VEC[i].exp, "R2 or R9 table");
      if (VEC[i].ofs == 8'h04) chk(pin_od, VEC[i].exp, "R8 pin_od");
    end
    wr(8'h10, 32'hFFFF_FFFF);
    // R6 input capture
    @(negedge clk) pin_in = 32'hA000_0000;
    settle();
    rd(8'h08, d); chk(d, 32'hA000_0000, "R6 data capture");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk(d, 32'h0, "R4 clear all");
    chk({31'b0, irq}, 32'h0, "R5 irq after clear");
    // R6 latency, R7 any edge on pin 3 (bit 28)
    @(negedge clk) pin_in = pin_in ^ 32'h1000_0000;
    @(negedge clk); @(negedge clk);
    chk({31'b0, irq}, 32'h0, "R6 sync latency");
    @(negedge clk);
    chk({31'b0, irq}, 32'h1, "R5 irq raised");
    rd(8'h0C, d); chk(d, 32'h1000_0000, "R7 rise sets event");
    wr(8'h0C, 32'h0000_0001);
    rd(8'h0C, d); chk(d, 32'h1000_0000, "R4 zero bits kept");
    wr(8'h0C, 32'h1000_0000);
    rd(8'h0C, d); chk(d, 32'h0, "R4 one bit cleared");
    // R7 falling-only on pin 5 (bit 26)
    wr(8'h14, 32'h0400_0000);
    @(negedge clk) pin_in = pin_in | 32'h0400_0000;
    settle();
    rd(8'h0C, d); chk(d, 32'h0, "R7 rise ignored");
    @(negedge clk) pin_in = pin_in & ~32'h0400_0000;
    settle();
    rd(8'h0C, d); chk(d, 32'h0400_0000, "R7 fall sets");
    wr(8'h0C, 32'hFFFF_FFFF);
    // R5 mask
    wr(8'h10, 32'h0);
    @(negedge clk) pin_in = pin_in ^ 32'h1000_0000;
    settle();
    chk({31'b0, irq}, 32'h0, "R5 masked");
    rd(8'h0C, d); chk(d, 32'h1000_0000, "R10 pending while masked");
    wr(8'h10, 32'h1000_0000);
    chk({31'b0, irq}, 32'h1, "R5 unmask");
    wr(8'h0C, 32'hFFFF_FFFF);
    // R6 / R8 output pin 7 (bit 24)
    wr(8'h00, 32'h0100_0000);
    @(negedge clk) pin_in = pin_in ^ 32'h0100_0000;
    settle();
    rd(8'h0C, d); chk(d, 32'h0, "R6 output pin no event");
    wr(8'h08, 32'hFFFF_FFFF);
    chk(pin_out, 32'h0100_0000, "R8 drive");
    chk(pin_oe, 32'h0100_0000, "R8 oe");
    wr(8'h08, 32'h0);
    chk(pin_out, 32'h0, "R8 drive low");
    rd(8'h08, d); chk(d, 32'hA000_0000, "R6 output pin not captured");
    // R9 narrow accesses
    wr(8'h00, 32'hFFFF_FFFF, 1'b0);
    rd(8'h00, d); chk(d, 32'h0100_0000, "R9 narrow write ignored");
    rd(8'h00, d, 1'b0); chk(d, 32'h0, "R9 narrow read zero");
    // R4 set wins over coincident clear, pin 3
    wr(8'h00, 32'h0);
    @(negedge clk) pin_in = pin_in ^ 32'h1000_0000;
    settle();
    @(negedge clk) pin_in = pin_in ^ 32'h1000_0000;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h0C; req_wdata = 32'h1000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    rd(8'h0C, d); chk(d, 32'h1000_0000, "R4 set wins");
    // R3 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
    @(negedge clk);
    req_valid = 1'b0;
    chk({31'b0, rsp_valid}, 32'h1, "R3 rsp valid");
    chk(rsp_data, 32'h1000_0000, "R3 rsp data");
    chk({31'b0, req_ready}, 32'h0, "R3 ready low");
    @(negedge clk);
    chk({31'b0, rsp_valid}, 32'h1, "R3 held valid");
    chk(rsp_data, 32'h1000_0000, "R3 held data");
    rsp_ready = 1'b1;
    @(negedge clk);
    chk({31'b0, rsp_valid}, 32'h0, "R3 released");
    finish_run();
  end
endmodule